// File: doc/BRIEF.md
# Counter-Sequenced Unsigned Multiplier

This block forms the product of two unsigned operands without an adder or a shifter anywhere in its datapath. It holds four reversible counters: two for the operands, one scratch counter and one for the product. Each counter can clear, load a value, step up by one or step down by one, and it reports when it holds zero. A small control state machine builds the product out of single steps. Each time it takes one unit off the first operand, it copies the second operand into the scratch counter. It then drains the scratch counter to zero and adds one to the product counter for every step.

A caller presents both operands and pulses `start` for one cycle while the unit is idle. The product counter is cleared on that edge and `busy` rises. When the first operand is exhausted, or either operand is zero, `busy` falls and `done` rises. The result stays on `product` until the next accepted start.

Top module: `cntmul_top`

## Requirements
- R1: While `rst` is high and on the first edge after it, `busy`, `done` and `product` are all zero.
- R2: A `start` sampled high while `busy` is low loads both operands and clears `product` on that edge. In the following cycle `busy` is 1 and `done` is 0.
- R3: When `done` rises, `product` equals `op_a * op_b` as captured at the accepted start, as an exact 8-bit unsigned value.
- R4: If either captured operand is zero, `done` rises with `product` equal to 0 on the second edge after the accepted start.
- R5: `done` rises exactly A*(B+2)+1 clock edges after the edge that accepts `start` when both operands are nonzero, and exactly 1 edge after it when either operand is zero.
- R6: A `start` pulse while `busy` is high is ignored. The running multiplication finishes with its original operands.
- R7: While `done` is high and `start` is low, `done` stays high and `product` does not change, whatever `op_a` and `op_b` do.
- R8: While `busy` is high, `product` changes by at most +1 per clock cycle and never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin; accepted only when not busy |
| op_a | input | OPW (4) | First operand, captured on an accepted start |
| op_b | input | OPW (4) | Second operand, captured on an accepted start |
| busy | output | 1 | Registered; high while the counters are sequencing |
| done | output | 1 | Registered; high from completion until the next accepted start |
| product | output | 2*OPW (8) | Product counter value |

## Verification
The assertions assume that `start` matters only when `busy` is low. They also assume that `op_a` and `op_b` are needed only in the cycle a start is accepted, so the zero-operand property reads them only there. The stimulus always drives inputs half a cycle away from the sampling edge. It keeps `start` to single-cycle pulses, except in the deliberate test that fires one into a running operation. It changes the operand inputs freely after capture to show that they no longer matter. Every operand pair in the 4-bit range is run, so each iteration count of both loops is reached.

// File: rtl/cntmul_pkg.sv
package cntmul_pkg;

  // Command applied to one reversible counter in one cycle
  typedef enum logic [2:0] {
    CNT_HOLD = 3'd0,
    CNT_CLR  = 3'd1,
    CNT_LOAD = 3'd2,
    CNT_INC  = 3'd3,
    CNT_DEC  = 3'd4
  } cnt_cmd_e;

  // Sequencer states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TEST = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

endpackage

// File: rtl/cntmul_counter.sv
module cntmul_counter
  import cntmul_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  cnt_cmd_e     cmd,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         zero
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] d;

  // Next-state gates: clear wins over load, load over counting
  always_comb begin
    unique case (cmd)
      CNT_CLR:  d = '0;
      CNT_LOAD: d = din;
      CNT_INC:  d = q + ONE;
      CNT_DEC:  d = q - ONE;
      default:  d = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  assign zero = ~|q;

endmodule

// File: rtl/cntmul_ctrl.sv
module cntmul_ctrl
  import cntmul_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     a_zero,
  input  logic     b_zero,
  input  logic     s_zero,
  output cnt_cmd_e cmd_a,
  output cnt_cmd_e cmd_b,
  output cnt_cmd_e cmd_s,
  output cnt_cmd_e cmd_c,
  output logic     busy,
  output logic     done
);

  seq_state_e st, nxt;

  always_comb begin
    nxt   = st;
    cmd_a = CNT_HOLD;
    cmd_b = CNT_HOLD;
    cmd_s = CNT_HOLD;
    cmd_c = CNT_HOLD;
    unique case (st)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          cmd_a = CNT_LOAD;
          cmd_b = CNT_LOAD;
          cmd_s = CNT_CLR;
          cmd_c = CNT_CLR;
          nxt   = ST_TEST;
        end
      end
      ST_TEST: begin
        // branch only on the zero flags of the outer operands
        if (a_zero || b_zero) begin
          nxt = ST_DONE;
        end else begin
          cmd_a = CNT_DEC;
          cmd_s = CNT_LOAD;
          nxt   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (s_zero) begin
          nxt = ST_TEST;
        end else begin
          cmd_s = CNT_DEC;
          cmd_c = CNT_INC;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      st   <= nxt;
      busy <= (nxt == ST_TEST) || (nxt == ST_RUN);
      done <= (nxt == ST_DONE);
    end
  end

endmodule

// File: rtl/cntmul_top.sv
module cntmul_top
  import cntmul_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OPW-1:0]   op_a,
  input  logic [OPW-1:0]   op_b,
  output logic             busy,
  output logic             done,
  output logic [2*OPW-1:0] product
);

  localparam int PRW = 2 * OPW;

  cnt_cmd_e cmd_a, cmd_b, cmd_s, cmd_c;
  logic [OPW-1:0] a_q, b_q, s_q;
  logic a_zero, b_zero, s_zero, c_zero;

  cntmul_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .a_zero (a_zero),
    .b_zero (b_zero),
    .s_zero (s_zero),
    .cmd_a  (cmd_a),
    .cmd_b  (cmd_b),
    .cmd_s  (cmd_s),
    .cmd_c  (cmd_c),
    .busy   (busy),
    .done   (done)
  );

  // Outer loop count
  cntmul_counter #(.W(OPW)) u_cnt_a (
    .clk (clk), .rst (rst), .cmd (cmd_a), .din (op_a), .q (a_q), .zero (a_zero)
  );

  // Second operand, kept for every outer pass
  cntmul_counter #(.W(OPW)) u_cnt_b (
    .clk (clk), .rst (rst), .cmd (cmd_b), .din (op_b), .q (b_q), .zero (b_zero)
  );

  // Scratch copy drained by the inner loop
  cntmul_counter #(.W(OPW)) u_cnt_s (
    .clk (clk), .rst (rst), .cmd (cmd_s), .din (b_q), .q (s_q), .zero (s_zero)
  );

  // Product accumulates by unit steps only
  cntmul_counter #(.W(PRW)) u_cnt_c (
    .clk (clk), .rst (rst), .cmd (cmd_c), .din ({PRW{1'b0}}), .q (product), .zero (c_zero)
  );

  logic unused_ok;
  assign unused_ok = ^{a_q, s_q};

endmodule

// File: rtl/cntmul_chk.sv
module cntmul_chk #(
  parameter int OPW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [OPW-1:0]   op_a,
  input logic [OPW-1:0]   op_b,
  input logic             busy,
  input logic             done,
  input logic [2*OPW-1:0] product,
  input logic             c_zero
);

  logic accept;
  assign accept = start && !busy;

  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (c_zero && busy && !done));

  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_zero_operand_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && (op_a == '0 || op_b == '0)) |-> ##2 (done && c_zero));

  p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(product)));

  p_unit_step_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> (product == $past(product) || product == $past(product) + 1'b1));

  p_ignore_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !c_zero || $past(c_zero));

endmodule

bind cntmul_top cntmul_chk #(.OPW(OPW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .op_a    (op_a),
  .op_b    (op_b),
  .busy    (busy),
  .done    (done),
  .product (product),
  .c_zero  (c_zero)
);

// File: tb/cntmul_top_tb.sv
module cntmul_top_tb;

  localparam int OPW = 4;
  localparam int PRW = 2 * OPW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [OPW-1:0] op_a = '0;
  logic [OPW-1:0] op_b = '0;
  logic busy, done;
  logic [PRW-1:0] product;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cntmul_top #(.OPW(OPW)) u_dut (
    .clk (clk), .rst (rst), .start (start), .op_a (op_a), .op_b (op_b),
    .busy (busy), .done (done), .product (product)
  );

  // {a, b, expected product}
  localparam logic [15:0] VEC [8] = '{
    {4'd0,  4'd0,  8'd0},
    {4'd0,  4'd9,  8'd0},
    {4'd7,  4'd0,  8'd0},
    {4'd1,  4'd1,  8'd1},
    {4'd15, 4'd15, 8'd225},
    {4'd15, 4'd1,  8'd15},
    {4'd1,  4'd15, 8'd15},
    {4'd12, 4'd11, 8'd132}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_lat(input int a, input int b);
    return (a == 0 || b == 0) ? 1 : a * (b + 2) + 1;
  endfunction

  task automatic run_mul(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                         output int p, output int lat,
                         output bit step_ok, output bit arm_ok);
    int prev;
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    arm_ok = busy && !done && (product == 0);
    prev = product; lat = 0; step_ok = 1'b1;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
      if (product != prev && product != prev + 1) step_ok = 1'b0;
      prev = product;
    end
    p = product;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p, lat, prev;
    bit sok, aok;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!busy && !done && product == 0, "R1", "reset outputs", product, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && product == 0, "R1", "after release", product, 0);

    // Table of corner pairs
    for (int i = 0; i < 8; i++) begin
      run_mul(VEC[i][15:12], VEC[i][11:8], p, lat, sok, aok);
      check(p == int'(VEC[i][7:0]), "R3", "table product", p, VEC[i][7:0]);
      check(lat == exp_lat(VEC[i][15:12], VEC[i][11:8]), "R5", "table latency",
            lat, exp_lat(VEC[i][15:12], VEC[i][11:8]));
      check(aok, "R2", "busy and cleared after start", int'(busy), 1);
      if (VEC[i][15:12] == 0 || VEC[i][11:8] == 0)
        check(p == 0 && lat == 1, "R4", "zero operand", p, 0);
    end

    // Exhaustive operand sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run_mul(a[3:0], b[3:0], p, lat, sok, aok);
        check(p == a * b, "R3", "sweep product", p, a * b);
        check(lat == exp_lat(a, b), "R5", "sweep latency", lat, exp_lat(a, b));
        check(sok, "R8", "unit step while busy", int'(sok), 1);
      end
    end

    // R6: start during a run is ignored
    @(negedge clk);
    op_a = 4'd5; op_b = 4'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    op_a = 4'd15; op_b = 4'd15; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
    check(product == 25, "R6", "start while busy ignored", product, 25);

    // R7: result held while done and inputs change
    op_a = 4'd3; op_b = 4'd3;
    prev = product;
    repeat (10) @(negedge clk);
    check(done && product == prev, "R7", "result held", product, prev);

    // R1: reset in the middle of a run
    @(negedge clk);
    op_a = 4'd9; op_b = 4'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!busy && !done && product == 0, "R1", "mid-run reset", product, 0);
    rst = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule